// File: doc/BRIEF.md
# Single-Bank DRAM Command Timing Sequencer

This block serves one DRAM bank. It takes one read or write request at a time, each with a row and a column address. It emits the Activate, Precharge, Read and Write commands that the request needs, in order, on a command bus. It keeps track of which row is open. A request to that row goes straight to the column command. A request to another row first closes the open row and then opens the new one. Core delays are counted in real memory clock cycles: activate-to-column, precharge-to-activate, activate-to-precharge, the read latency and the command rate after chip select. These delays come from configuration inputs, which the block samples only while it is idle.

For each Read it issues, the block marks the cycles in which returned data is valid. It raises a strobe on the first beat, exactly one read latency after the command. It then keeps the strobe up for the rest of the burst on back-to-back cycles, with a beat index. In every cycle where no command is legal, the bus carries a NOP.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_cs is 0, cmd_code is NOP (0) and rd_valid is 0. The bank starts closed with every timer expired, so the first request produces an Activate followed by its column command and no Precharge.
- R2: Command codes on cmd_code are NOP=0, ACT=1, RD=2, WR=3 and PRE=4. An ACT carries the row on cmd_addr. RD and WR carry the column, zero-extended. NOP and PRE carry 0.
- R3: A RD or WR is issued no sooner than cfg_trcd cycles after the ACT of its row. When nothing else blocks it, it is issued exactly cfg_trcd cycles after the ACT.
- R4: An ACT is issued no sooner than cfg_trp cycles after the preceding PRE. When nothing else blocks it, it is issued exactly cfg_trp cycles after the PRE.
- R5: A PRE is issued no sooner than cfg_tras cycles after the last ACT. When a miss arrives early, the PRE is issued exactly cfg_tras cycles after that ACT.
- R6: After a RD, rd_valid is 1 for BL consecutive cycles. The first of these cycles is exactly cfg_cl cycles after the RD, and rd_beat counts 0 to BL-1 over them. A WR produces no rd_valid.
- R7: cmd_cs rises in the cycle after a request is accepted. The first command of that request comes 1 cycle after cmd_cs rises when cfg_cr2=0, and 2 cycles after when cfg_cr2=1.
- R8: A request to the open row issues no PRE or ACT. A request to another row issues PRE, then ACT, then the column command. On such a miss with the timers expired, the first read beat comes exactly cfg_trp+cfg_trcd+cfg_cl cycles after the PRE.
- R9: req_ready is 0 from the cycle after acceptance through the cycle of the column command. The configuration inputs are sampled only while req_ready is 1. Changing them while a request is in service has no effect on its timing.
- R10: While cmd_cs is 0, cmd_code is NOP. Any cycle in which no command is legal carries NOP.
- R11: A column command waits while read beats from an earlier RD are still due. It is issued in the cycle after the last beat when nothing else blocks it.
- R12: A timing value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl | input | TW | Read latency in cycles |
| cfg_trcd | input | TW | Activate to column command delay |
| cfg_trp | input | TW | Precharge to activate delay |
| cfg_tras | input | TW | Activate to precharge delay |
| cfg_cr2 | input | 1 | Command rate: 0 = one cycle, 1 = two cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cmd_cs | output | 1 | Chip select, high while a request is in service |
| cmd_code | output | 3 | Command code |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column address of the command |
| rd_valid | output | 1 | Read data beat valid |
| rd_beat | output | log2(BL) | Index of the current beat |

## Verification
The requests are tried from a closed bank, to the open row, to a different row once the timers have expired, and to a different row straight after an Activate. These cases separate the Activate, the hit path, the full miss path and the activate-to-precharge hold. Back-to-back reads to the open row show whether the column command waits for the earlier burst. A write shows that no beats are produced. A second timing set with the two-cycle command rate, changed mid-request, shows that every delay is taken from the sampled settings and not the live inputs.

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int TW    = 5,
  parameter int BL    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW-1:0]        cfg_cl,
  input  logic [TW-1:0]        cfg_trcd,
  input  logic [TW-1:0]        cfg_trp,
  input  logic [TW-1:0]        cfg_tras,
  input  logic                 cfg_cr2,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  output logic                 cmd_cs,
  output logic [2:0]           cmd_code,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
  output logic                 rd_valid,
  output logic [((BL > 1) ? $clog2(BL) : 1)-1:0] rd_beat
);
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int BW = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

  typedef enum logic [1:0] {RS_IDLE, RS_WAIT, RS_BURST} rs_t;

  function automatic logic [TW-1:0] m1(input logic [TW-1:0] v);
    m1 = (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic             busy, p_wr;
  logic [ROW_W-1:0] p_row, open_row;
  logic [COL_W-1:0] p_col;
  logic             open_q;
  logic [TW-1:0]    cl_q, trcd_q, trp_q, tras_q;
  logic [1:0]       cr_cnt;
  logic [TW-1:0]    trcd_cnt, trp_cnt, tras_cnt, rd_cnt;
  rs_t              rd_st;
  logic [BW-1:0]    beat;
  logic [2:0]       sel;

  wire hit    = open_q && (open_row == p_row);
  wire go     = busy && (cr_cnt == 2'd0);
  wire rd_idl = (rd_st == RS_IDLE);
  wire accept = req_valid && !busy;

  always_comb begin
    sel = C_NOP;
    if (go) begin
      if (hit) begin
        if (trcd_cnt == '0 && rd_idl) sel = p_wr ? C_WR : C_RD;
      end else if (open_q) begin
        if (tras_cnt == '0) sel = C_PRE;
      end else if (trp_cnt == '0) begin
        sel = C_ACT;
      end
    end
  end

  always_comb begin
    cmd_addr = '0;
    if (sel == C_ACT) cmd_addr = AW'(p_row);
    else if (sel == C_RD || sel == C_WR) cmd_addr = AW'(p_col);
  end

  assign cmd_code  = sel;
  assign cmd_cs    = busy;
  assign req_ready = !busy;
  assign rd_valid  = (rd_st == RS_BURST);
  assign rd_beat   = beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q <= 1; trcd_q <= 1; trp_q <= 1; tras_q <= 1;
    end else if (!busy) begin
      cl_q <= cfg_cl; trcd_q <= cfg_trcd; trp_q <= cfg_trp; tras_q <= cfg_tras;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; p_wr <= 1'b0; p_row <= '0; p_col <= '0; cr_cnt <= 2'd0;
    end else if (accept) begin
      busy   <= 1'b1;
      p_wr   <= req_write;
      p_row  <= req_row;
      p_col  <= req_col;
      cr_cnt <= cfg_cr2 ? 2'd2 : 2'd1;
    end else if (busy) begin
      if (cr_cnt != 2'd0) cr_cnt <= cr_cnt - 2'd1;
      if (sel == C_RD || sel == C_WR) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trcd_cnt <= '0; trp_cnt <= '0; tras_cnt <= '0;
      open_q <= 1'b0; open_row <= '0;
    end else begin
      trcd_cnt <= m1(trcd_cnt);
      trp_cnt  <= m1(trp_cnt);
      tras_cnt <= m1(tras_cnt);
      if (sel == C_ACT) begin
        trcd_cnt <= m1(trcd_q);
        tras_cnt <= m1(tras_q);
        open_q   <= 1'b1;
        open_row <= p_row;
      end else if (sel == C_PRE) begin
        trp_cnt <= m1(trp_q);
        open_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_st <= RS_IDLE; rd_cnt <= '0; beat <= '0;
    end else begin
      case (rd_st)
        RS_WAIT: begin
          if (rd_cnt == TW'(1)) begin rd_st <= RS_BURST; beat <= '0; end
          else rd_cnt <= rd_cnt - 1'b1;
        end
        RS_BURST: begin
          if (beat == BW'(BL - 1)) rd_st <= RS_IDLE;
          else beat <= beat + 1'b1;
        end
        default: ;
      endcase
      if (sel == C_RD) begin
        if (cl_q <= TW'(1)) begin rd_st <= RS_BURST; beat <= '0; end
        else begin rd_st <= RS_WAIT; rd_cnt <= cl_q - 1'b1; end
      end
    end
  end

  logic [TW-1:0] since_act, since_pre;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '1; since_pre <= '1;
    end else begin
      since_act <= (sel == C_ACT) ? TW'(1) : ((since_act == '1) ? since_act : since_act + 1'b1);
      since_pre <= (sel == C_PRE) ? TW'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
    end
  end

  a_r3_trcd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_RD || cmd_code == C_WR) |-> since_act >= trcd_q);
  a_r4_trp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_ACT) |-> since_pre >= trp_q);
  a_r5_tras: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_PRE) |-> since_act >= tras_q);
  a_r10_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cs |-> cmd_code == C_NOP);
  a_r6_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != BW'(BL - 1)) |=> (rd_valid && rd_beat == $past(rd_beat) + 1'b1));
  a_r9_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/dram_bank_seq_tb_top.sv
`timescale 1ns/1ps
module dram_bank_seq_tb_top;
  localparam int BL = 4;
  logic clk = 0, rst_n = 0;
  logic [4:0] cfg_cl, cfg_trcd, cfg_trp, cfg_tras;
  logic cfg_cr2;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_row = 0;
  logic [5:0] req_col = 0;
  wire req_ready, cmd_cs, rd_valid;
  wire [2:0] cmd_code;
  wire [7:0] cmd_addr;
  wire [1:0] rd_beat;

  dram_bank_seq #(.ROW_W(8), .COL_W(6), .TW(5), .BL(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_tras(cfg_tras), .cfg_cr2(cfg_cr2), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .cmd_cs(cmd_cs),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .rd_valid(rd_valid), .rd_beat(rd_beat));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int t_cs, t_act, t_pre, t_col, t_b0, t_blast;
  int n_act = 0, n_pre = 0, n_col = 0, n_beats = 0;
  int col_code, col_addr, act_addr;
  int seq_err = 0, nop_err = 0, rdy_err = 0;
  bit cs_prev = 0, v_prev = 0;
  int b_prev = 0, c_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cmd_cs && !cs_prev) t_cs = cyc;
    cs_prev = cmd_cs;
    if (!cmd_cs && cmd_code != 0) nop_err++;
    if (cmd_cs && req_ready) rdy_err++;
    case (cmd_code)
      3'd1: begin t_act = cyc; act_addr = cmd_addr; n_act++; end
      3'd4: begin t_pre = cyc; n_pre++; end
      3'd2, 3'd3: begin t_col = cyc; col_code = cmd_code; col_addr = cmd_addr; n_col++; end
      default: ;
    endcase
    if (rd_valid) begin
      if (rd_beat == 0) t_b0 = cyc;
      else if (!(v_prev && rd_beat == b_prev + 1 && cyc == c_prev + 1)) seq_err++;
      if (rd_beat == BL - 1) t_blast = cyc;
      n_beats++;
    end
    v_prev = rd_valid; b_prev = rd_beat; c_prev = cyc;
  end

  task automatic check(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic set_cfg(int cl, int rcd, int rp, int ras, bit cr2);
    cfg_cl = cl; cfg_trcd = rcd; cfg_trp = rp; cfg_tras = ras; cfg_cr2 = cr2;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(bit wr, int row, int col, bit swap);
    int nc;
    nc = n_col;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_row = row; req_col = col;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R9 ready low after accept", req_ready, 0);
    check("R7 cs high after accept", cmd_cs, 1);
    if (swap) set_cfg(9, 9, 9, 24, 0);
    while (n_col == nc) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 cs", cmd_cs, 0);
    check("R1 cmd NOP", cmd_code, 0);
    check("R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_cold;
    int na, np, nb;
    na = n_act; np = n_pre; nb = n_beats;
    req(0, 5, 9, 0);
    check("R1 one ACT from closed", n_act - na, 1);
    check("R1 no PRE from closed", n_pre - np, 0);
    check("R2 ACT row", act_addr, 5);
    check("R7 1T first cmd", t_act - t_cs, 1);
    check("R3 trcd exact", t_col - t_act, 7);
    check("R2 RD code", col_code, 2);
    check("R2 RD column", col_addr, 9);
    settle(20);
    check("R6 first beat after CL", t_b0 - t_col, 7);
    check("R6 last beat", t_blast - t_b0, BL - 1);
    check("R6 beat count", n_beats - nb, BL);
  endtask

  task automatic t_hit;
    int na, np;
    na = n_act; np = n_pre;
    req(0, 5, 12, 0);
    check("R8 hit no ACT", n_act - na, 0);
    check("R8 hit no PRE", n_pre - np, 0);
    check("R7 hit col at cs+1", t_col - t_cs, 1);
    check("R2 hit column", col_addr, 12);
    settle(20);
  endtask

  task automatic t_miss;
    req(0, 9, 3, 0);
    check("R8 PRE first on miss", t_pre - t_cs, 1);
    check("R4 trp exact", t_act - t_pre, 7);
    check("R2 miss ACT row", act_addr, 9);
    check("R3 trcd after miss", t_col - t_act, 7);
    settle(20);
    check("R8 miss cost", t_b0 - t_pre, 21);
  endtask

  task automatic t_tras;
    int a4;
    req(0, 4, 1, 0);
    a4 = t_act;
    req(0, 6, 2, 0);
    check("R5 tras hold", t_pre - a4, 18);
    check("R4 trp after tras", t_act - t_pre, 7);
    settle(20);
  endtask

  task automatic t_write;
    int nb;
    nb = n_beats;
    req(1, 6, 7, 0);
    check("R2 WR code", col_code, 3);
    check("R2 WR column", col_addr, 7);
    settle(20);
    check("R6 write gives no beats", n_beats - nb, 0);
  endtask

  task automatic t_rdblock;
    int r1;
    req(0, 6, 1, 0);
    r1 = t_col;
    req(0, 6, 2, 0);
    check("R11 column waits for burst", t_col - r1, 7 + BL);
    check("R11 col after last beat", t_col - t_blast, 1);
    settle(20);
  endtask

  task automatic t_2t_swap;
    set_cfg(5, 4, 3, 10, 1);
    settle(3);
    req(0, 2, 5, 1);
    check("R7 2T first cmd", t_pre - t_cs, 2);
    check("R9 trp from sampled cfg", t_act - t_pre, 3);
    check("R9 trcd from sampled cfg", t_col - t_act, 4);
    settle(20);
    check("R9 CL from sampled cfg", t_b0 - t_col, 5);
    req(0, 2, 6, 0);
    check("R7 1T after resample", t_col - t_cs, 1);
    settle(20);
    check("R9 new CL used", t_b0 - t_col, 9);
  endtask

  task automatic t_zero;
    int nb;
    set_cfg(0, 0, 0, 0, 0);
    settle(3);
    nb = n_beats;
    req(0, 11, 4, 0);
    check("R12 zero trp as 1", t_act - t_pre, 1);
    check("R12 zero trcd as 1", t_col - t_act, 1);
    settle(10);
    check("R12 zero CL as 1", t_b0 - t_col, 1);
    check("R12 beats", n_beats - nb, BL);
  endtask

  initial begin
    set_cfg(7, 7, 7, 18, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_cold();
    t_hit();
    t_miss();
    t_tras();
    t_write();
    t_rdblock();
    t_2t_swap();
    t_zero();
    check("R6 beat sequence errors", seq_err, 0);
    check("R10 command while cs low", nop_err, 0);
    check("R9 ready while busy", rdy_err, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule